// File: doc/BRIEF.md
# Flash Byte-Program Sequencer

This block sits on the host side of an asynchronous 8-bit parallel flash. It programs one byte at a time. A client hands it a target address and a data byte over a valid/ready handshake. The sequencer then drives the chip-enable, write-enable and output-enable strobes, the address pins and the data pins through the three-write unlock preamble followed by the data write. Every setup, pulse-width and hold interval is counted in clock cycles. Each count comes from a nanosecond parameter divided by the clock period and rounded up.

Once the fourth write has finished, the sequencer reads the target address repeatedly. It stops when the flash returns bit 7 equal to bit 7 of the byte that was written. It then pulses `done` for one cycle. If no matching read happens within a programmable timeout window, `done` is pulsed together with `err`. Only one program operation is in flight at a time. `req_ready` is high only while the sequencer is idle.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After a request is accepted, exactly four write strobes are issued, in this order: 0xAA to address 0x5555, 0x55 to address 0x2AAA, 0xA0 to address 0x5555, and then the request byte to the request address.
- R2: Each write-enable low pulse lasts at least ceil(TWP_NS/CLK_NS) cycles, which is 9 at a 10 ns clock. Between two pulses of one operation, write-enable stays high for at least ceil(TWPH_NS/CLK_NS) cycles, which is also 9 at 10 ns.
- R3: While write-enable is low, chip-enable is low, and the address and data pins do not change. They also do not change at the clock edge where write-enable returns high.
- R4: Output-enable is high whenever write-enable is low. The data-drive enable `flash_doe` is high during write cycles and never while output-enable is low.
- R5: Polling reads the target address with chip-enable and output-enable low. Each read holds output-enable low for ceil(TACC_NS/CLK_NS)+1 cycles, which is 7 at 10 ns. The operation completes with a one-cycle `done` pulse and `err` low when the sampled bit 7 equals bit 7 of the written byte, and not while the flash still returns the complemented bit.
- R6: If no read matches within ceil(TOUT_NS/CLK_NS) cycles of the start of polling, `done` pulses with `err` high at the end of the next read. That is no earlier than the window and no more than one read-plus-gap period after it.
- R7: `req_ready` is high only while idle, and a request is taken when `req_valid` and `req_ready` are both high. Changing `req_addr` or `req_data` after acceptance has no effect on the bytes or addresses written.
- R8: During and after reset, chip-enable, write-enable and output-enable are high, `flash_doe`, `done` and `err` are low, and `req_ready` is high.
- R9: In the cycle after `done`, chip-enable is high and `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout indication, valid with done |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_addr | output | AW | Flash address pins |
| flash_dout | output | 8 | Data driven toward the flash |
| flash_doe | output | 1 | Drive enable for flash_dout |
| flash_din | input | 8 | Data returned by the flash |

## Verification
The hardest situation to reach from the ports is a poll read that falls while the flash is still busy but after its access time. In that case only bit 7 betrays the incomplete program. Another hard case is a read sampled too early, before the access time has passed. The bench's flash model keeps every bit except bit 7 plausible while busy. It toggles bit 6 on each read. It also presents the complemented bit 7 until output-enable has been low for the full access window. Random busy durations, including zero, then move the completion point across read boundaries. Stuck-busy operations with both bit-7 polarities drive the timeout path.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

  typedef enum logic [1:0] {
    WC_IDLE,
    WC_SETUP,
    WC_LOW,
    WC_HIGH
  } wc_phase_e;

  typedef enum logic [1:0] {
    PL_IDLE,
    PL_READ,
    PL_GAP
  } pl_phase_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_WRITE,
    CT_POLL,
    CT_DONE
  } ct_state_e;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLOCK_BYTE_A = 8'hAA;
  localparam logic [7:0]  UNLOCK_BYTE_B = 8'h55;
  localparam logic [7:0]  PROGRAM_BYTE  = 8'hA0;

  function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned per);
    cyc_ceil = (ns + per - 1) / per;
  endfunction

  function automatic int unsigned cmax(input int unsigned a, input int unsigned b);
    cmax = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_pgm_wcycle.sv
module flash_pgm_wcycle
  import flash_pgm_pkg::*;
#(
  parameter int unsigned SU_CYC   = 1,
  parameter int unsigned LOW_CYC  = 5,
  parameter int unsigned HIGH_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic we_n,
  output logic last
);

  localparam int unsigned MAX_CYC = cmax(cmax(SU_CYC, LOW_CYC), cmax(HIGH_CYC, 2));
  localparam int unsigned CW      = $clog2(MAX_CYC);
  localparam logic [CW-1:0] SU_LD   = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] LOW_LD  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LD = CW'(HIGH_CYC - 1);

  wc_phase_e     phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          we_n_q, we_n_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign last     = (phase_q == WC_HIGH) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (phase_q)
      WC_IDLE: begin
        if (start) begin
          phase_d = WC_SETUP;
          cnt_d   = SU_LD;
          cnt_en  = 1'b1;
        end
      end
      WC_SETUP: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          phase_d = WC_LOW;
          cnt_d   = LOW_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      WC_LOW: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          phase_d = WC_HIGH;
          cnt_d   = HIGH_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      WC_HIGH: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          if (start) begin
            phase_d = WC_SETUP;
            cnt_d   = SU_LD;
          end else begin
            phase_d = WC_IDLE;
            cnt_d   = '0;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = WC_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
    we_n_d = (phase_d != WC_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WC_IDLE;
      cnt_q   <= '0;
      we_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      we_n_q  <= we_n_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign we_n = we_n_q;

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == WC_IDLE || last)); // R1

  AST_LOW_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_q) |-> ($past(phase_q) == WC_SETUP)); // R2

endmodule

// File: rtl/flash_pgm_poll.sv
module flash_pgm_poll
  import flash_pgm_pkg::*;
#(
  parameter int unsigned RD_CYC  = 4,
  parameter int unsigned GAP_CYC = 1,
  parameter int unsigned TO_CYC  = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic expect_b7,
  input  logic sample_b7,
  output logic oe_n,
  output logic fin,
  output logic fail
);

  localparam int unsigned CW = $clog2(cmax(cmax(RD_CYC, GAP_CYC), 2));
  localparam int unsigned TW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TO_VAL = TW'(TO_CYC);

  pl_phase_e     phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tcnt_en;
  logic          expired;
  logic          oe_n_q, oe_n_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign expired  = (tcnt_q == TO_VAL);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    fin     = 1'b0;
    fail    = 1'b0;
    case (phase_q)
      PL_IDLE: begin
        if (start) begin
          phase_d = PL_READ;
          cnt_d   = RD_LD;
          cnt_en  = 1'b1;
        end
      end
      PL_READ: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          if (sample_b7 == expect_b7) begin
            fin     = 1'b1;
            phase_d = PL_IDLE;
          end else if (expired) begin
            fin     = 1'b1;
            fail    = 1'b1;
            phase_d = PL_IDLE;
          end else begin
            phase_d = PL_GAP;
            cnt_d   = GAP_LD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PL_GAP: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          phase_d = PL_READ;
          cnt_d   = RD_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PL_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
    oe_n_d = (phase_d != PL_READ);
  end

  always_comb begin
    tcnt_d  = tcnt_q;
    tcnt_en = 1'b0;
    if (start) begin
      tcnt_d  = '0;
      tcnt_en = 1'b1;
    end else if (phase_q != PL_IDLE && !expired) begin
      tcnt_d  = tcnt_q + 1'b1;
      tcnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PL_IDLE;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      oe_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      oe_n_q  <= oe_n_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (tcnt_en) tcnt_q <= tcnt_d;
    end
  end

  assign oe_n = oe_n_q;

  AST_POLL_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == PL_IDLE)); // R5

  AST_FAIL_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (tcnt_q == TO_VAL)); // R6

endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import flash_pgm_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned TSU_NS   = 0,
  parameter int unsigned TWP_NS   = 90,
  parameter int unsigned TWPH_NS  = 90,
  parameter int unsigned TDS_NS   = 50,
  parameter int unsigned TAH_NS   = 50,
  parameter int unsigned TACC_NS  = 55,
  parameter int unsigned TGAP_NS  = 20,
  parameter int unsigned TOUT_NS  = 60000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          err,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dout,
  output logic          flash_doe,
  input  logic [7:0]    flash_din
);

  localparam int unsigned SU_CYC   = cmax(cyc_ceil(TSU_NS, CLK_NS), 1);
  localparam int unsigned LOW_CYC  = cmax(cmax(cyc_ceil(TWP_NS, CLK_NS), cyc_ceil(TDS_NS, CLK_NS)),
                                          cmax(cyc_ceil(TAH_NS, CLK_NS), 1));
  localparam int unsigned HIGH_CYC = cmax(cyc_ceil(TWPH_NS, CLK_NS), 1);
  localparam int unsigned RD_CYC   = cyc_ceil(TACC_NS, CLK_NS) + 1;
  localparam int unsigned GAP_CYC  = cmax(cyc_ceil(TGAP_NS, CLK_NS), 1);
  localparam int unsigned TO_CYC   = cmax(cyc_ceil(TOUT_NS, CLK_NS), 1);
  localparam logic [1:0]  LAST_STEP = 2'd3;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  ct_state_e     state_q, state_d;
  logic [1:0]    step_q, step_d;
  logic          cap_en;
  logic [AW-1:0] tgt_addr_q, tgt_addr_d;
  logic [7:0]    tgt_data_q, tgt_data_d;
  logic          wstart, wlast, pstart, pfin, pfail;
  logic          we_n_w, oe_n_p;
  logic          ce_n_q, ce_n_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    dout_q, dout_d;
  logic          doe_q, doe_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  function automatic logic [AW-1:0] step_addr(input logic [1:0] s, input logic [AW-1:0] tgt);
    case (s)
      2'd0:    step_addr = AW'(UNLOCK_ADDR_A);
      2'd1:    step_addr = AW'(UNLOCK_ADDR_B);
      2'd2:    step_addr = AW'(UNLOCK_ADDR_A);
      default: step_addr = tgt;
    endcase
  endfunction

  function automatic logic [7:0] step_byte(input logic [1:0] s, input logic [7:0] tgt);
    case (s)
      2'd0:    step_byte = UNLOCK_BYTE_A;
      2'd1:    step_byte = UNLOCK_BYTE_B;
      2'd2:    step_byte = PROGRAM_BYTE;
      default: step_byte = tgt;
    endcase
  endfunction

  // sequencing of the four writes and the poll phase
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    cap_en  = 1'b0;
    wstart  = 1'b0;
    pstart  = 1'b0;
    case (state_q)
      CT_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          step_d  = 2'd0;
          wstart  = 1'b1;
          state_d = CT_WRITE;
        end
      end
      CT_WRITE: begin
        if (wlast) begin
          if (step_q == LAST_STEP) begin
            pstart  = 1'b1;
            state_d = CT_POLL;
          end else begin
            step_d = step_q + 1'b1;
            wstart = 1'b1;
          end
        end
      end
      CT_POLL: begin
        if (pfin) state_d = CT_DONE;
      end
      CT_DONE: begin
        state_d = CT_IDLE;
      end
      default: state_d = CT_IDLE;
    endcase
  end

  // registered pin drive, computed from next state
  always_comb begin
    tgt_addr_d = cap_en ? req_addr : tgt_addr_q;
    tgt_data_d = cap_en ? req_data : tgt_data_q;
    addr_d     = addr_q;
    dout_d     = dout_q;
    if (state_d == CT_WRITE) begin
      addr_d = step_addr(step_d, tgt_addr_d);
      dout_d = step_byte(step_d, tgt_data_d);
    end else if (state_d == CT_POLL) begin
      addr_d = tgt_addr_d;
    end
    doe_d  = (state_d == CT_WRITE);
    ce_n_d = !((state_d == CT_WRITE) || (state_d == CT_POLL));
    done_d = (state_d == CT_DONE);
    err_d  = (state_q == CT_POLL) && pfin && pfail;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q    <= CT_IDLE;
      step_q     <= 2'd0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      ce_n_q     <= 1'b1;
      addr_q     <= '0;
      dout_q     <= '0;
      doe_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (cap_en) begin
        tgt_addr_q <= tgt_addr_d;
        tgt_data_q <= tgt_data_d;
      end
      ce_n_q <= ce_n_d;
      addr_q <= addr_d;
      dout_q <= dout_d;
      doe_q  <= doe_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  flash_pgm_wcycle #(
    .SU_CYC   (SU_CYC),
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC)
  ) u_wcycle (
    .clk   (clk),
    .rst_n (rst_sn),
    .start (wstart),
    .we_n  (we_n_w),
    .last  (wlast)
  );

  flash_pgm_poll #(
    .RD_CYC  (RD_CYC),
    .GAP_CYC (GAP_CYC),
    .TO_CYC  (TO_CYC)
  ) u_poll (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start     (pstart),
    .expect_b7 (tgt_data_q[7]),
    .sample_b7 (flash_din[7]),
    .oe_n      (oe_n_p),
    .fin       (pfin),
    .fail      (pfail)
  );

  assign req_ready  = (state_q == CT_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign flash_ce_n = ce_n_q;
  assign flash_we_n = we_n_w;
  assign flash_oe_n = oe_n_p;
  assign flash_addr = addr_q;
  assign flash_dout = dout_q;
  assign flash_doe  = doe_q;

  AST_OE_HIGH_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    !flash_we_n |-> flash_oe_n); // R4

  AST_NO_DRIVE_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    !flash_oe_n |-> !flash_doe); // R4

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_sn)
    !flash_we_n |-> !flash_ce_n); // R3

  AST_BUS_STABLE_WE_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dout))); // R3

  AST_BUS_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dout))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    err |-> done); // R6

  AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    req_ready |-> flash_ce_n); // R9

endmodule

// File: tb/flash_pgm_ctrl_test.sv
module flash_pgm_ctrl_test;

  localparam int B_WP   = 9;    // ceil(90/10)
  localparam int B_WPH  = 9;    // ceil(90/10)
  localparam int B_RD   = 7;    // ceil(55/10)+1
  localparam int B_TO   = 400;  // ceil(4000/10)
  localparam int B_TOHI = 440;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [7:0]  req_data;
  logic        done;
  logic        err;
  logic        flash_ce_n;
  logic        flash_we_n;
  logic        flash_oe_n;
  logic [15:0] flash_addr;
  logic [7:0]  flash_dout;
  logic        flash_doe;
  logic [7:0]  flash_din;

  int checks;
  int fails;
  int cyc;

  // flash model state, owned by the monitor
  int          op_seq;
  int          seen_seq;
  int          mcfg_busy;
  logic        mcfg_stuck;
  logic        op_active;
  int          wr_n;
  logic [15:0] log_a [4];
  logic [7:0]  log_d [4];
  int          busy_cnt;
  logic [7:0]  ld;
  logic        tog;
  int          oe_low_cnt;
  logic        prev_we;
  logic        prev_oe;
  int          low_len;
  int          high_len;
  logic [15:0] lat_a;
  logic [7:0]  lat_d;
  int          t_rise;
  int          viol_width;
  int          viol_stab;
  int          viol_oe;
  int          viol_ready;
  logic        mbusy;
  logic        rd_ok;

  flash_pgm_ctrl #(
    .CLK_NS  (10),
    .TOUT_NS (4000)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .done       (done),
    .err        (err),
    .flash_ce_n (flash_ce_n),
    .flash_we_n (flash_we_n),
    .flash_oe_n (flash_oe_n),
    .flash_addr (flash_addr),
    .flash_dout (flash_dout),
    .flash_doe  (flash_doe),
    .flash_din  (flash_din)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  assign mbusy     = mcfg_stuck || (busy_cnt != 0);
  assign rd_ok     = (oe_low_cnt >= B_RD) && !mbusy;
  assign flash_din = rd_ok ? ld : {~ld[7], tog, ld[5:0]};

  function automatic logic [15:0] exp_a(input int i, input logic [15:0] a);
    case (i)
      0:       exp_a = 16'h5555;
      1:       exp_a = 16'h2AAA;
      2:       exp_a = 16'h5555;
      default: exp_a = a;
    endcase
  endfunction

  function automatic logic [7:0] exp_d(input int i, input logic [7:0] d);
    case (i)
      0:       exp_d = 8'hAA;
      1:       exp_d = 8'h55;
      2:       exp_d = 8'hA0;
      default: exp_d = d;
    endcase
  endfunction

  // port monitor and flash behaviour
  always @(negedge clk) begin
    if (op_seq != seen_seq) begin
      seen_seq = op_seq;
      wr_n     = 0;
      busy_cnt = 0;
      high_len = 0;
      low_len  = 0;
      ld       = 8'h00;
    end
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (!flash_oe_n && !flash_ce_n) begin
      if (prev_oe) tog = ~tog;
      oe_low_cnt = oe_low_cnt + 1;
    end else begin
      oe_low_cnt = 0;
    end
    if (!flash_we_n) begin
      if (prev_we) begin
        if (wr_n > 0 && high_len < B_WPH) viol_width = viol_width + 1;
        low_len = 0;
        lat_a   = flash_addr;
        lat_d   = flash_dout;
      end
      low_len = low_len + 1;
      if (flash_addr != lat_a || flash_dout != lat_d || flash_ce_n) viol_stab = viol_stab + 1;
      if (!flash_oe_n || !flash_doe) viol_oe = viol_oe + 1;
    end else begin
      if (!prev_we) begin
        if (low_len < B_WP) viol_width = viol_width + 1;
        if (flash_addr != lat_a || flash_dout != lat_d) viol_stab = viol_stab + 1;
        if (wr_n < 4) begin
          log_a[wr_n] = lat_a;
          log_d[wr_n] = lat_d;
        end
        wr_n = wr_n + 1;
        if (wr_n == 4) begin
          busy_cnt = mcfg_busy;
          ld       = lat_d;
        end
        t_rise   = cyc;
        high_len = 0;
      end
      high_len = high_len + 1;
    end
    if (flash_doe && !flash_oe_n) viol_oe = viol_oe + 1;
    if (op_active && req_ready) viol_ready = viol_ready + 1;
    prev_we = flash_we_n;
    prev_oe = flash_oe_n;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [7:0] d, input int bz,
                        input logic stk, input logic exp_err);
    int n;
    int vw, vs, vo, vr;
    int t_done;
    logic mism;
    vw = viol_width; vs = viol_stab; vo = viol_oe; vr = viol_ready;
    @(negedge clk); #1;
    op_seq     = op_seq + 1;
    mcfg_busy  = bz;
    mcfg_stuck = stk;
    req_valid  = 1'b1;
    req_addr   = a;
    req_data   = d;
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 1'b0;
    req_addr  = ~a;        // R7: late change must be ignored
    req_data  = ~d;
    op_active = 1'b1;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk); #1;
      n = n + 1;
    end
    t_done = cyc;
    chk(done, "R5", "done seen", done, 1);
    chk(err == exp_err, exp_err ? "R6" : "R5", "err at done", err, exp_err);
    chk(wr_n == 4, "R1", "write count", wr_n, 4);
    mism = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (log_a[i] != exp_a(i, a) || log_d[i] != exp_d(i, d)) begin
        mism = 1'b1;
        chk(1'b0, "R1/R7", "write addr/data", {log_a[i], log_d[i]}, {exp_a(i, a), exp_d(i, d)});
      end
    end
    if (!mism) chk(1'b1, "R1", "write log", 0, 0);
    if (!exp_err) begin
      chk(!mbusy, "R5", "done only after flash ready", mbusy, 0);
    end else begin
      chk((t_done - t_rise) >= B_TO && (t_done - t_rise) <= B_TOHI, "R6",
          "timeout latency", t_done - t_rise, B_TO);
    end
    chk(viol_width == vw, "R2", "write pulse widths", viol_width - vw, 0);
    chk(viol_stab == vs, "R3", "addr/data stable", viol_stab - vs, 0);
    chk(viol_oe == vo, "R4", "oe/doe during writes", viol_oe - vo, 0);
    chk(viol_ready == vr, "R7", "ready low while busy", viol_ready - vr, 0);
    op_active = 1'b0;
    @(negedge clk); #1;
    chk(flash_ce_n && req_ready && !done, "R9", "idle after done",
        {flash_ce_n, req_ready, done}, 3'b110);
    mcfg_stuck = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    fails  = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; cyc = 0;
    op_seq = 0; seen_seq = 0; mcfg_busy = 0; mcfg_stuck = 1'b0; op_active = 1'b0;
    wr_n = 0; busy_cnt = 0; ld = 8'h00; tog = 1'b0; oe_low_cnt = 0;
    prev_we = 1'b1; prev_oe = 1'b1; low_len = 0; high_len = 0;
    lat_a = '0; lat_d = '0; t_rise = 0;
    viol_width = 0; viol_stab = 0; viol_oe = 0; viol_ready = 0;
    for (int i = 0; i < 4; i++) begin log_a[i] = '0; log_d[i] = '0; end
    void'($urandom(32'd7319));
    req_valid = 1'b0; req_addr = '0; req_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(flash_ce_n && flash_we_n && flash_oe_n && !flash_doe && !done && !err, "R8",
        "pins in reset", {flash_ce_n, flash_we_n, flash_oe_n, flash_doe, done, err}, 6'b111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(flash_ce_n && flash_we_n && flash_oe_n && !flash_doe && req_ready, "R8",
        "pins after reset", {flash_ce_n, flash_we_n, flash_oe_n, flash_doe, req_ready}, 5'b11101);

    run_op(16'h0000, 8'h00, 0,   1'b0, 1'b0);
    run_op(16'hFFFF, 8'hFF, 50,  1'b0, 1'b0);
    run_op(16'h1234, 8'h80, 0,   1'b0, 1'b0);
    run_op(16'h5555, 8'h7F, 123, 1'b0, 1'b0);
    run_op(16'hABCD, 8'h5A, 0,   1'b1, 1'b1);   // R6 bit7 = 0
    run_op(16'h8000, 8'hC3, 0,   1'b1, 1'b1);   // R6 bit7 = 1
    run_op(16'h2AAA, 8'h01, 7,   1'b0, 1'b0);
    for (int k = 0; k < 20; k++) begin
      run_op(16'($urandom()), 8'($urandom()), int'($urandom_range(0, 300)), 1'b0, 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule